// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Slave Timing)

This block sends a pair of 20-bit PCM samples, left and right, out over one serial data line. It never makes its own serial timing. An external master drives the bit clock and the word-select line, and both are sampled in the block's own system clock domain. A static format input picks the framing:

- Delayed framing (I2S): the most significant bit trails the word-select change by one bit clock.
- Left-justified framing: the most significant bit leads off in the bit slot where the word-select change happens.

Samples arrive in parallel with a one-cycle strobe and go into a staging pair. At the start of every stereo frame the staging pair is copied into a holding pair, and the shifter reads only the holding pair. A power control input parks the block. After each power-up, the data line stays low for a programmable number of frames, until the upstream filter has settled.

Top module: `audio_ser_tx`

## Requirements
- R1: `sdata` changes only in response to a falling bit-clock edge, seen as `bck` sampled high on one `clk` edge and low on the next. The new bit is visible right after that second `clk` edge and holds until the next falling edge.
- R2: With `fmt_lj` = 0 (I2S), the MSB of a word is driven on the first falling bit-clock edge after the one where `ws` changed.
- R3: With `fmt_lj` = 1 (left-justified), the MSB of a word is driven on the same falling bit-clock edge where `ws` changed.
- R4: Words go out MSB first. Every bit position of a half-frame beyond the 20 data bits is driven as 0.
- R5: `ws` = 0 carries the left word and `ws` = 1 carries the right word. A frame starts when `ws` goes from 1 to 0.
- R6: In I2S framing, the bit driven on the edge where `ws` changes is the next pending bit of the previous word. With a 20-bit slot, that bit is the previous word's LSB.
- R7: After `pwr_on` rises, or after reset, the first HOLD_FRAMES frames are driven all 0. The next frame carries data, including its first bit.
- R8: While `pwr_on` = 0, `sdata` is 0 at once. All staged and held data is cleared, and the power-up hold-off restarts. After reset, `sdata` is 0.
- R9: A strobe on `smp_vld` stores `smp_l`/`smp_r` in staging. A frame sends the staging values that were present when it started. A strobe during a frame does not change that frame.
- R10: A strobe in the same `clk` cycle as a frame start reaches staging after the copy into holding, so it first goes out in the following frame.
- R11: When a slot is shorter than 20 bit clocks, only its leading bits go out. In I2S framing, the unsent remainder still supplies the first bit of the next slot (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample bck and ws |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = run, 0 = powered down |
| bck | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the master: 0 = left, 1 = right |
| fmt_lj | input | 1 | Static framing select: 0 = I2S, 1 = left-justified |
| smp_l | input | 20 | Left sample |
| smp_r | input | 20 | Right sample |
| smp_vld | input | 1 | One-cycle strobe that loads smp_l/smp_r into staging |
| sdata | output | 1 | Serial data output |

## Verification
The interesting collision happens when a sample strobe lands in the same system-clock cycle as the falling bit-clock edge that opens a frame. The staging-to-holding copy and the staging write then happen at once. The bench provokes this by raising `smp_vld` on the same clock phase that drops `bck` and lowers `ws`. It then checks the outcome: the following frame, not the current one, must carry the new words. The end of the hold-off also coincides with a frame start, so in I2S framing the bench checks that the first unmuted bit comes from the new frame's rule.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int W           = 20,
  parameter int HOLD_FRAMES = 12288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_on,
  input  logic         bck,
  input  logic         ws,
  input  logic         fmt_lj,
  input  logic [W-1:0] smp_l,
  input  logic [W-1:0] smp_r,
  input  logic         smp_vld,
  output logic         sdata
);
  localparam int CW = $clog2(HOLD_FRAMES + 1);

  logic         bck_q, ws_prev, dout_r, load_pend, mute;
  logic [W-1:0] stg_l, stg_r, hold_l, hold_r, sreg, word;
  logic [CW-1:0] hold_cnt;
  logic         fall, trans, start;

  assign fall  = bck_q & ~bck;
  assign trans = fall & (ws ^ ws_prev);
  assign start = trans & ~ws;
  assign sdata = pwr_on & ~mute & dout_r;

  always_comb begin
    if (fmt_lj) word = ws ? hold_r : (start ? stg_l : hold_l);
    else        word = ws_prev ? hold_r : hold_l;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bck_q <= 1'b0;
    else        bck_q <= bck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b1; dout_r <= 1'b0; load_pend <= 1'b0; mute <= 1'b1;
      stg_l <= '0; stg_r <= '0; hold_l <= '0; hold_r <= '0; sreg <= '0;
      hold_cnt <= '0;
    end else if (!pwr_on) begin
      ws_prev <= 1'b1; dout_r <= 1'b0; load_pend <= 1'b0; mute <= 1'b1;
      stg_l <= '0; stg_r <= '0; hold_l <= '0; hold_r <= '0; sreg <= '0;
      hold_cnt <= '0;
    end else begin
      if (smp_vld) begin
        stg_l <= smp_l;
        stg_r <= smp_r;
      end
      if (fall) begin
        ws_prev <= ws;
        if (start) begin
          hold_l <= stg_l;
          hold_r <= stg_r;
          if (hold_cnt < CW'(HOLD_FRAMES)) begin
            hold_cnt <= hold_cnt + 1'b1;
            mute     <= 1'b1;
          end else begin
            mute     <= 1'b0;
          end
        end
        if ((trans && fmt_lj) || (load_pend && !trans)) begin
          dout_r <= word[W-1];
          sreg   <= {word[W-2:0], 1'b0};
        end else begin
          dout_r <= sreg[W-1];
          sreg   <= {sreg[W-2:0], 1'b0};
        end
        load_pend <= trans & ~fmt_lj;
      end
    end
  end

  AST_QUIET_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n) (pwr_on && !fall) |=> (!pwr_on || $stable(dout_r))); // R1
  AST_PDN_RESTARTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pwr_on |=> (mute && hold_cnt == '0 && !dout_r)); // R8
  AST_HOLD_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n) (pwr_on && !start) |=> (!pwr_on || ($stable(hold_l) && $stable(hold_r)))); // R9
  AST_UNMUTE_AT_START: assert property (@(posedge clk) disable iff (!rst_n) $fell(mute) |-> $past(start)); // R7
  AST_HOLD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) 32'(hold_cnt) <= HOLD_FRAMES); // R7
endmodule

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  localparam int HOLD = 3;
  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, bck = 1'b1, ws = 1'b1, fmt_lj = 1'b0, smp_vld = 1'b0;
  logic [19:0] smp_l = '0, smp_r = '0;
  logic sdata;
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [19:0] m_stg_l, m_stg_r, m_cur_l, m_cur_r, prev_w;
  int prev_slot, fcnt, gseq;

  always #2 clk = ~clk;

  audio_ser_tx #(.W(20), .HOLD_FRAMES(HOLD)) u_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bck(bck), .ws(ws), .fmt_lj(fmt_lj),
    .smp_l(smp_l), .smp_r(smp_r), .smp_vld(smp_vld), .sdata(sdata));

  function automatic logic [19:0] gen(input int n);
    return 20'((n * 32'h0002F3B7 + 32'h0005A5A1) ^ (n << 7));
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: sdata=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bitcyc(input logic w, input logic strobe, input logic [19:0] nl, input logic [19:0] nr,
                        input logic e, input string req);
    @(negedge clk); bck = 1'b0; ws = w;
    if (strobe) begin smp_l = nl; smp_r = nr; smp_vld = 1'b1; end
    @(negedge clk); smp_vld = 1'b0; chk(sdata, e, "R1");
    @(negedge clk);
    @(negedge clk); chk(sdata, e, req); bck = 1'b1;
  endtask

  task automatic run_frame(input int slot, input bit mid, input bit edge_s, input bit edge_prev);
    for (int h = 0; h < 2; h++) begin
      logic [19:0] w;
      for (int p = 0; p < slot; p++) begin
        logic strobe, e;
        logic [19:0] nl, nr;
        int idx;
        string req;
        bit muted;
        strobe = 0; nl = '0; nr = '0;
        if (h == 0 && p == 0 && pwr_on) begin
          fcnt++;
          m_cur_l = m_stg_l; m_cur_r = m_stg_r;
        end
        if ((h == 0 && p == 0 && edge_s) || (h == 0 && p == 3 && mid)) begin
          strobe = 1; nl = gen(gseq); nr = gen(gseq + 1); gseq += 2;
        end
        w = h ? m_cur_r : m_cur_l;
        if (fmt_lj) e = (p < 20) ? w[19-p] : 1'b0;
        else if (p == 0) begin
          idx = prev_slot - 1;
          e = (idx < 20) ? prev_w[19-idx] : 1'b0;
        end else begin
          idx = p - 1;
          e = (idx < 20) ? w[19-idx] : 1'b0;
        end
        muted = !pwr_on || fcnt <= HOLD;
        if (muted) e = 1'b0;
        if (!pwr_on) req = "R8";
        else if (muted) req = "R7";
        else if (fmt_lj && p == 0) req = "R3";
        else if (!fmt_lj && p == 1) req = "R2";
        else if (!fmt_lj && p == 0) req = "R6";
        else if (p >= 20) req = "R4";
        else if (slot < 20) req = "R11";
        else if (edge_prev) req = "R10";
        else if (h == 1) req = "R5";
        else req = "R9";
        bitcyc(logic'(h), strobe, nl, nr, e, req);
        if (strobe && pwr_on) begin m_stg_l = nl; m_stg_r = nr; end
      end
      prev_w = pwr_on ? w : '0;
      prev_slot = slot;
    end
  endtask

  task automatic power_down();
    @(negedge clk); pwr_on = 1'b0;
    #1 chk(sdata, 1'b0, "R8");
    m_stg_l = '0; m_stg_r = '0; m_cur_l = '0; m_cur_r = '0; prev_w = '0; fcnt = 0;
  endtask

  initial begin
    m_stg_l = '0; m_stg_r = '0; m_cur_l = '0; m_cur_r = '0; prev_w = '0;
    prev_slot = 32; fcnt = 0; gseq = 1;
    repeat (3) @(negedge clk);
    chk(sdata, 1'b0, "R8");
    rst_n = 1'b1; pwr_on = 1'b1; fmt_lj = 1'b0;
    for (int n = 0; n < 6; n++) run_frame(32, 1, 0, 0);
    run_frame(20, 1, 0, 0); run_frame(20, 1, 0, 0);
    run_frame(24, 1, 0, 0);
    run_frame(16, 1, 0, 0); run_frame(16, 0, 0, 0);
    run_frame(32, 0, 1, 0); run_frame(32, 0, 0, 1);
    power_down();
    run_frame(32, 1, 0, 0); run_frame(32, 1, 0, 0);
    fmt_lj = 1'b1;
    @(negedge clk); pwr_on = 1'b1;
    for (int n = 0; n < 5; n++) run_frame(32, 1, 0, 0);
    run_frame(20, 1, 0, 0); run_frame(20, 1, 0, 0);
    run_frame(16, 1, 0, 0); run_frame(16, 0, 0, 0);
    run_frame(32, 0, 1, 0); run_frame(32, 0, 0, 1);
    power_down();
    run_frame(32, 0, 0, 0);
    fmt_lj = 1'b0;
    @(negedge clk); pwr_on = 1'b1;
    for (int n = 0; n < 4; n++) run_frame(20, 1, 0, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule